// File: doc/BRIEF.md
# Queued Asynchronous Serial Transceiver with Fractional Rate and Receiver Wakeup

This block sends and receives asynchronous serial characters. Each character has one low start bit, 8 or 9 data bits sent least significant bit first, and one high stop bit. Characters to send enter a 4-entry queue through a valid/ready stream. Received characters leave a 4-entry queue through a second valid/ready stream. The rate generator makes a sample tick at 16 times the bit rate. Its divisor has a 13-bit integer part and a 3-bit fractional part. The receiver takes the bit value from the middle samples of each bit and reports disagreement among them as noise.

The receiver can be put to sleep. While it sleeps it stores nothing. It wakes in one of two ways: on a character that carries an address mark, or on a line that stays idle for a full character time. A single-wire mode lets the receiver listen to the block's own transmit line. In that mode the transmit driver is enabled only while a character is being sent, so the line can be shared.

Back-pressure rules:
- The transmit side accepts a character on every clock edge where `tx_valid` and `tx_ready` are both high.
- The receive side releases a character on every clock edge where `rx_valid` and `rx_ready` are both high.
- While `rx_ready` is low, `rx_data` holds its value.
- The line cannot be stalled. A character that arrives while the receive queue is full is therefore dropped and flagged.

Top module: `uart_fd`

## Requirements
- R1: After reset, `tx_ready`=1, `rx_valid`=0, `txd`=1, `txd_oe`=1, `asleep`=0, `noise_flag`=0 and `overrun_flag`=0.
- R2: A transmitted character is:
  - a low start bit;
  - data bits sent least significant first, 8 of them when `nine_bit`=0 and 9 when `nine_bit`=1;
  - a high stop bit.
- R3: The transmit queue keeps characters in order. With one character in the shifter and 4 waiting, `tx_ready` is 0.
- R4: A received character appears on `rx_data` (bit 8 is 0 in 8-bit mode). It stays stable while `rx_valid`=1 and `rx_ready`=0.
- R5: The receive queue holds 4 characters in order. A fifth character that arrives while the queue is full is dropped and sets `overrun_flag`. The flag stays set until a `flag_clr` pulse.
- R6: One bit lasts 16 sample ticks. A tick normally lasts `baud_int` clocks. In every 8 consecutive ticks, `baud_frac` of them last one clock longer, so a bit lasts 16·`baud_int`+2·`baud_frac` clocks. A `baud_int` of 0 acts as 1.
- R7: The bit value is the majority of samples 7, 8 and 9 of the bit. Any disagreement among those three samples in a stored character sets `noise_flag`. The flag stays set until `flag_clr`.
- R8: A start bit whose vote is high is rejected, and no character is produced.
- R9: A `sleep_req` pulse sets `asleep`. Characters that complete while the receiver is asleep and do not wake it are not stored.
- R10: With `wake_mode`=1, a character whose top data bit is set clears `asleep` and is stored. The top data bit is bit 7, or bit 8 when `nine_bit`=1.
- R11: With `wake_mode`=0, `asleep` clears after the receiver has been idle with the line high for one full character time: 160 ticks, or 176 ticks in 9-bit mode.
- R12: With `single_wire`=1, the receiver listens to `txd` and ignores `rxd`, and `txd_oe` is 1 only while a character is being sent. With `single_wire`=0, `txd_oe` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_int | input | 13 | Integer part of the tick divisor |
| baud_frac | input | 3 | Fractional part of the tick divisor, in eighths |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| single_wire | input | 1 | 1 selects shared-line half-duplex operation |
| wake_mode | input | 1 | 1 wakes on an address mark, 0 wakes on an idle line |
| sleep_req | input | 1 | Pulse that puts the receiver to sleep |
| flag_clr | input | 1 | Pulse that clears the noise and overrun flags |
| tx_data | input | 9 | Character to send |
| tx_valid | input | 1 | Transmit stream valid |
| tx_ready | output | 1 | Transmit queue has room |
| rx_data | output | 9 | Received character |
| rx_valid | output | 1 | Receive queue is not empty |
| rx_ready | input | 1 | Consumer takes the head character |
| rxd | input | 1 | Serial input line |
| txd | output | 1 | Serial output line |
| txd_oe | output | 1 | Output enable for the transmit driver |
| asleep | output | 1 | Receiver is sleeping |
| noise_flag | output | 1 | Sticky flag: noise seen in a stored character |
| overrun_flag | output | 1 | Sticky flag: a character was dropped because the queue was full |

## Verification
With a divisor of 1, a bit lasts 16 clocks. The bench drives `rxd` one slot per clock on the falling edge. The input passes two synchronizer stages, so a received character reaches the queue about 10 bit times after its start edge. The bench waits for `rx_valid` with a bound and never samples at a fixed cycle.

For the transmit side, the bench finds the start edge and then samples each bit 8 clocks past its edge, which is the middle of the bit. For fractional rates, it counts the clocks the start bit stays low and compares the count with 16·`baud_int`+2·`baud_frac`. That count is exact wherever the accumulator starts.

The wakeup results are due on known ticks. The bench reads `asleep` inside a window that falls clearly before or clearly after the wake tick. All outputs are read on the falling clock edge.

// File: rtl/uart_fd_pkg.sv
package uart_fd_pkg;
  localparam int CHAR_W = 9;
  typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_st_t;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_t;
endpackage

// File: rtl/uart_fd_tick.sv
module uart_fd_tick #(
  parameter int INT_W  = 13,
  parameter int FRAC_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INT_W-1:0]  baud_int,
  input  logic [FRAC_W-1:0] baud_frac,
  output logic              tick
);
  localparam int CW = INT_W + 1;

  logic [CW-1:0]     cnt;
  logic [CW-1:0]     lim;
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   sum;
  logic              extra;

  // A divisor of 0 behaves as 1; one extra clock is added when the
  // fractional accumulator carried on the previous tick.
  always_comb begin
    lim  = ((baud_int == '0) ? CW'(1) : {1'b0, baud_int}) - CW'(1) + CW'(extra);
    tick = (cnt >= lim);
    sum  = {1'b0, acc} + {1'b0, baud_frac};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      acc   <= '0;
      extra <= 1'b0;
    end else if (tick) begin
      cnt   <= '0;
      acc   <= sum[FRAC_W-1:0];
      extra <= sum[FRAC_W];
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/uart_fd_fifo.sv
module uart_fd_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in_data,
  input  logic         in_valid,
  output logic         in_ready,
  output logic [W-1:0] out_data,
  output logic         out_valid,
  input  logic         out_ready
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push, pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign in_ready  = (cnt != CW'(DEPTH));
  assign out_valid = (cnt != '0);
  assign out_data  = mem[rp];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end
endmodule

// File: rtl/uart_fd_tx.sv
module uart_fd_tx
  import uart_fd_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              nine_bit,
  input  logic [CHAR_W-1:0] q_data,
  input  logic              q_valid,
  output logic              q_pop,
  output logic              txd_o,
  output logic              busy
);
  localparam int SW = $clog2(OSR);

  tx_st_t            st;
  logic [SW-1:0]     sub;
  logic [3:0]        bitn;
  logic [CHAR_W-1:0] shreg;
  logic              bit_end;
  logic [3:0]        last;

  assign bit_end = tick && (sub == SW'(OSR - 1));
  assign last    = nine_bit ? 4'd8 : 4'd7;
  // Load a new character when idle, or straight after a stop bit ends.
  assign q_pop   = q_valid && tick && ((st == TX_IDLE) || (st == TX_STOP && bit_end));
  assign busy    = (st != TX_IDLE);

  always_comb begin
    case (st)
      TX_START: txd_o = 1'b0;
      TX_DATA:  txd_o = shreg[0];
      default:  txd_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= TX_IDLE;
      sub   <= '0;
      bitn  <= '0;
      shreg <= '0;
    end else if (q_pop) begin
      st    <= TX_START;
      sub   <= '0;
      shreg <= q_data;
    end else if (tick && st != TX_IDLE) begin
      sub <= bit_end ? '0 : sub + 1'b1;
      if (bit_end) begin
        case (st)
          TX_START: begin
            st   <= TX_DATA;
            bitn <= '0;
          end
          TX_DATA: begin
            shreg <= shreg >> 1;
            if (bitn == last) st <= TX_STOP;
            else              bitn <= bitn + 1'b1;
          end
          default: st <= TX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_fd_rx.sv
module uart_fd_rx
  import uart_fd_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              line,
  input  logic              nine_bit,
  output logic              ch_valid,
  output logic [CHAR_W-1:0] ch_data,
  output logic              ch_noise,
  output logic              idle
);
  localparam int NW  = $clog2(OSR + 1);
  localparam int MID = OSR / 2;

  rx_st_t            st;
  logic [NW-1:0]     sub;
  logic [NW-1:0]     n;
  logic [3:0]        bitn;
  logic [3:0]        last;
  logic [CHAR_W-1:0] shreg;
  logic              s_a, s_b, nz;
  logic              vote, dis;

  // n is the number of the sample taken on this tick (1..OSR).
  assign n    = (sub == NW'(OSR)) ? NW'(1) : sub + 1'b1;
  assign last = nine_bit ? 4'd8 : 4'd7;
  assign vote = (s_a & s_b) | (s_a & line) | (s_b & line);
  assign dis  = !((s_a == s_b) && (s_b == line));
  assign idle = (st == RX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= RX_IDLE;
      sub      <= '0;
      bitn     <= '0;
      shreg    <= '0;
      s_a      <= 1'b1;
      s_b      <= 1'b1;
      nz       <= 1'b0;
      ch_valid <= 1'b0;
      ch_data  <= '0;
      ch_noise <= 1'b0;
    end else begin
      ch_valid <= 1'b0;
      if (tick) begin
        if (st == RX_IDLE) begin
          if (!line) begin
            st    <= RX_START;
            sub   <= NW'(1);
            nz    <= 1'b0;
            shreg <= '0;
          end
        end else begin
          sub <= n;
          if (n == NW'(MID - 1)) s_a <= line;
          if (n == NW'(MID))     s_b <= line;
          if (n == NW'(MID + 1)) begin
            nz <= nz | dis;
            case (st)
              RX_START: if (vote) st <= RX_IDLE;
              RX_DATA:  shreg <= {vote, shreg[CHAR_W-1:1]};
              RX_STOP: begin
                ch_valid <= 1'b1;
                ch_data  <= nine_bit ? shreg : {1'b0, shreg[CHAR_W-1:1]};
                ch_noise <= nz | dis;
                st       <= RX_IDLE;
              end
              default: st <= RX_IDLE;
            endcase
          end
          if (n == NW'(OSR)) begin
            case (st)
              RX_START: begin
                st   <= RX_DATA;
                bitn <= '0;
              end
              RX_DATA: begin
                if (bitn == last) st <= RX_STOP;
                else              bitn <= bitn + 1'b1;
              end
              default: st <= st;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/uart_fd.sv
module uart_fd
  import uart_fd_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int OSR        = 16,
  parameter int INT_W      = 13,
  parameter int FRAC_W     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INT_W-1:0]  baud_int,
  input  logic [FRAC_W-1:0] baud_frac,
  input  logic              nine_bit,
  input  logic              single_wire,
  input  logic              wake_mode,
  input  logic              sleep_req,
  input  logic              flag_clr,
  input  logic [CHAR_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  input  logic              rxd,
  output logic              txd,
  output logic              txd_oe,
  output logic              asleep,
  output logic              noise_flag,
  output logic              overrun_flag
);
  localparam int IDLE8  = OSR * 10;
  localparam int IDLE9  = OSR * 11;
  localparam int IDLE_W = $clog2(IDLE9 + 1);

  logic              tick;
  logic [CHAR_W-1:0] txq_data;
  logic              txq_valid, txq_pop, tx_busy;
  logic [1:0]        sync_q;
  logic              line;
  logic              ch_valid, ch_noise, rx_idle;
  logic [CHAR_W-1:0] ch_data;
  logic              rxq_in_ready;
  logic              mark, mark_wake, idle_wake, store;
  logic [IDLE_W-1:0] idle_cnt, idle_target;

  uart_fd_tick #(.INT_W(INT_W), .FRAC_W(FRAC_W)) tick_i (
    .clk(clk), .rst(rst), .baud_int(baud_int), .baud_frac(baud_frac), .tick(tick)
  );

  uart_fd_fifo #(.W(CHAR_W), .DEPTH(FIFO_DEPTH)) txq_i (
    .clk(clk), .rst(rst),
    .in_data(tx_data), .in_valid(tx_valid), .in_ready(tx_ready),
    .out_data(txq_data), .out_valid(txq_valid), .out_ready(txq_pop)
  );

  uart_fd_tx #(.OSR(OSR)) tx_i (
    .clk(clk), .rst(rst), .tick(tick), .nine_bit(nine_bit),
    .q_data(txq_data), .q_valid(txq_valid), .q_pop(txq_pop),
    .txd_o(txd), .busy(tx_busy)
  );

  assign txd_oe = !single_wire || tx_busy;

  // Receive source: own transmit line in shared-wire mode.
  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], single_wire ? txd : rxd};
  end
  assign line = sync_q[1];

  uart_fd_rx #(.OSR(OSR)) rx_i (
    .clk(clk), .rst(rst), .tick(tick), .line(line), .nine_bit(nine_bit),
    .ch_valid(ch_valid), .ch_data(ch_data), .ch_noise(ch_noise), .idle(rx_idle)
  );

  // Wakeup and store decision
  assign mark        = nine_bit ? ch_data[8] : ch_data[7];
  assign mark_wake   = asleep && wake_mode && ch_valid && mark;
  assign store       = ch_valid && (!asleep || mark_wake);
  assign idle_target = nine_bit ? IDLE_W'(IDLE9) : IDLE_W'(IDLE8);
  assign idle_wake   = asleep && !wake_mode && (idle_cnt == idle_target);

  always_ff @(posedge clk) begin
    if (rst || sleep_req || !asleep || !rx_idle || !line) idle_cnt <= '0;
    else if (tick && idle_cnt != idle_target)           idle_cnt <= idle_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                         asleep <= 1'b0;
    else if (sleep_req)              asleep <= 1'b1;
    else if (mark_wake || idle_wake) asleep <= 1'b0;
  end

  uart_fd_fifo #(.W(CHAR_W), .DEPTH(FIFO_DEPTH)) rxq_i (
    .clk(clk), .rst(rst),
    .in_data(ch_data), .in_valid(store), .in_ready(rxq_in_ready),
    .out_data(rx_data), .out_valid(rx_valid), .out_ready(rx_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      overrun_flag <= 1'b0;
      noise_flag   <= 1'b0;
    end else begin
      if (store && !rxq_in_ready) overrun_flag <= 1'b1;
      else if (flag_clr)          overrun_flag <= 1'b0;
      if (store && ch_noise)      noise_flag <= 1'b1;
      else if (flag_clr)          noise_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_fd_chk.sv
module uart_fd_chk (
  input logic       clk,
  input logic       rst,
  input logic [8:0] rx_data,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       overrun_flag,
  input logic       noise_flag,
  input logic       flag_clr,
  input logic       single_wire,
  input logic       txd,
  input logic       txd_oe,
  input logic       sleep_req,
  input logic       asleep
);
  // R4
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
  // R5
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (overrun_flag && !flag_clr) |=> overrun_flag);
  // R7
  noise_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (noise_flag && !flag_clr) |=> noise_flag);
  // R12
  oe_full_chk: assert property (@(posedge clk) disable iff (rst)
    !single_wire |-> txd_oe);
  // R12
  line_rest_chk: assert property (@(posedge clk) disable iff (rst)
    !txd_oe |-> txd);
  // R9
  sleep_set_chk: assert property (@(posedge clk) disable iff (rst)
    sleep_req |=> asleep);
endmodule

bind uart_fd uart_fd_chk chk_i (
  .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .overrun_flag(overrun_flag), .noise_flag(noise_flag), .flag_clr(flag_clr),
  .single_wire(single_wire), .txd(txd), .txd_oe(txd_oe),
  .sleep_req(sleep_req), .asleep(asleep)
);

// File: tb/uart_fd_tb_top.sv
`timescale 1ns/1ps
module uart_fd_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst;
  logic [12:0] baud_int;
  logic [2:0]  baud_frac;
  logic        nine_bit, single_wire, wake_mode, sleep_req, flag_clr;
  logic [8:0]  tx_data;
  logic        tx_valid, tx_ready;
  logic [8:0]  rx_data;
  logic        rx_valid, rx_ready;
  logic        rxd, txd, txd_oe, asleep, noise_flag, overrun_flag;

  int checks = 0;
  int errors = 0;

  uart_fd dut_i (
    .clk(clk), .rst(rst), .baud_int(baud_int), .baud_frac(baud_frac),
    .nine_bit(nine_bit), .single_wire(single_wire), .wake_mode(wake_mode),
    .sleep_req(sleep_req), .flag_clr(flag_clr),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rxd(rxd), .txd(txd), .txd_oe(txd_oe), .asleep(asleep),
    .noise_flag(noise_flag), .overrun_flag(overrun_flag)
  );

  // {nine_bit, data}
  localparam logic [9:0] VEC [6] = '{10'h055, 10'h0A3, 10'h0FF, 10'h000, 10'h3C6, 10'h2A5};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_rx(input logic [8:0] d, input bit nine, input int gb);
    int nb;
    nb = nine ? 9 : 8;
    for (int b = 0; b < nb + 2; b++) begin
      logic v;
      if (b == 0)       v = 1'b0;
      else if (b <= nb) v = d[b-1];
      else              v = 1'b1;
      for (int s = 0; s < 16; s++) begin
        @(negedge clk);
        rxd = v ^ ((b == gb) && (s == 7));
      end
    end
    @(negedge clk);
    rxd = 1'b1;
  endtask

  task automatic push_tx(input logic [8:0] d);
    @(negedge clk);
    tx_data  = d;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic decode_tx(input bit nine, output logic [8:0] d);
    int t;
    int nb;
    t  = 0;
    nb = nine ? 9 : 8;
    d  = '0;
    while (txd !== 1'b0 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    repeat (8) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      repeat (16) @(negedge clk);
      d[i] = txd;
    end
    repeat (16) @(negedge clk);
    chk("R2 stop bit", 32'(txd), 32'h1);
  endtask

  task automatic pull_rx(output logic [8:0] d);
    int t;
    t = 0;
    while (!rx_valid && t < 1000) begin
      @(negedge clk);
      t++;
    end
    d = rx_data;
    @(negedge clk);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic start_width(output int w);
    push_tx(9'h001);
    while (txd !== 1'b0) @(negedge clk);
    w = 0;
    while (txd === 1'b0 && w < 1000) begin
      @(negedge clk);
      w++;
    end
    repeat (700) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [8:0] got;
    logic [8:0] arr [5];
    int w;
    rst = 1'b1; baud_int = 13'd1; baud_frac = 3'd0; nine_bit = 1'b0;
    single_wire = 1'b0; wake_mode = 1'b0; sleep_req = 1'b0; flag_clr = 1'b0;
    tx_data = '0; tx_valid = 1'b0; rx_ready = 1'b0; rxd = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 tx_ready", 32'(tx_ready), 1);
    chk("R1 rx_valid", 32'(rx_valid), 0);
    chk("R1 txd", 32'(txd), 1);
    chk("R1 txd_oe", 32'(txd_oe), 1);
    chk("R1 asleep", 32'(asleep), 0);
    chk("R1 flags", {30'd0, noise_flag, overrun_flag}, 0);

    // Vector table: R2 transmit, R4 receive, R7 clean frames
    for (int i = 0; i < 6; i++) begin
      logic       nine;
      logic [8:0] d, e;
      nine = VEC[i][9];
      d    = VEC[i][8:0];
      e    = nine ? d : {1'b0, d[7:0]};
      @(negedge clk);
      nine_bit = nine;
      push_tx(d);
      decode_tx(nine, got);
      chk("R2 tx character", 32'(got), 32'(e));
      send_rx(d, nine, -1);
      pull_rx(got);
      chk("R4 rx character", 32'(got), 32'(e));
      chk("R7 clean frame no noise", 32'(noise_flag), 0);
    end
    @(negedge clk);
    nine_bit = 1'b0;

    // R3 transmit queue depth and order
    fork
      begin
        for (int k = 0; k < 5; k++) push_tx(9'h030 + 9'(k));
        @(negedge clk);
        chk("R3 tx_ready low when full", 32'(tx_ready), 0);
      end
      begin
        for (int k = 0; k < 5; k++) decode_tx(1'b0, arr[k]);
      end
    join
    for (int k = 0; k < 5; k++) chk("R3 tx order", 32'(arr[k]), 32'h30 + 32'(k));

    // R5 receive queue depth, order, overrun drop
    for (int k = 0; k < 5; k++) send_rx(9'h011 + 9'(k), 1'b0, -1);
    repeat (20) @(negedge clk);
    chk("R5 overrun set", 32'(overrun_flag), 1);
    for (int k = 0; k < 4; k++) begin
      pull_rx(got);
      chk("R5 rx order", 32'(got), 32'h11 + 32'(k));
    end
    @(negedge clk);
    chk("R5 fifth dropped", 32'(rx_valid), 0);
    pulse_clr();
    chk("R5 flag_clr", 32'(overrun_flag), 0);

    // R7 noise: one glitched sample in data bit 2 (frame bit 3)
    send_rx(9'h03C, 1'b0, 3);
    pull_rx(got);
    chk("R7 majority value", 32'(got), 32'h3C);
    chk("R7 noise set", 32'(noise_flag), 1);
    pulse_clr();
    chk("R7 flag_clr", 32'(noise_flag), 0);

    // R8 false start: short low pulse
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      rxd = 1'b0;
    end
    @(negedge clk);
    rxd = 1'b1;
    repeat (200) @(negedge clk);
    chk("R8 false start no char", 32'(rx_valid), 0);

    // R9 / R10 address-mark wake
    @(negedge clk);
    wake_mode = 1'b1;
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    chk("R9 asleep set", 32'(asleep), 1);
    send_rx(9'h012, 1'b0, -1);
    repeat (20) @(negedge clk);
    chk("R9 unmarked dropped", 32'(rx_valid), 0);
    chk("R10 stays asleep", 32'(asleep), 1);
    send_rx(9'h093, 1'b0, -1);
    pull_rx(got);
    chk("R10 marked char stored", 32'(got), 32'h93);
    chk("R10 woke", 32'(asleep), 0);

    // R11 idle-line wake
    @(negedge clk);
    wake_mode = 1'b0;
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    send_rx(9'h055, 1'b0, -1);
    repeat (100) @(negedge clk);
    chk("R11 still asleep before idle time", 32'(asleep), 1);
    chk("R9 char dropped while asleep", 32'(rx_valid), 0);
    repeat (100) @(negedge clk);
    chk("R11 woke after idle time", 32'(asleep), 0);

    // R6 fractional timing (start bit of 0x001)
    @(negedge clk);
    baud_int = 13'd2; baud_frac = 3'd4;
    start_width(w);
    chk("R6 int2 frac4", 32'(w), 40);
    @(negedge clk);
    baud_frac = 3'd1;
    start_width(w);
    chk("R6 int2 frac1", 32'(w), 34);
    @(negedge clk);
    baud_int = 13'd3; baud_frac = 3'd0;
    start_width(w);
    chk("R6 int3 frac0", 32'(w), 48);
    @(negedge clk);
    baud_int = 13'd0;
    start_width(w);
    chk("R6 int0 acts as 1", 32'(w), 16);
    @(negedge clk);
    baud_int = 13'd1;

    // R12 single-wire
    @(negedge clk);
    single_wire = 1'b1;
    @(negedge clk);
    rxd = 1'b0;
    repeat (5) @(negedge clk);
    chk("R12 oe low idle", 32'(txd_oe), 0);
    push_tx(9'h05A);
    repeat (4) @(negedge clk);
    chk("R12 oe high sending", 32'(txd_oe), 1);
    pull_rx(got);
    chk("R12 hears own line", 32'(got), 32'h5A);
    repeat (200) @(negedge clk);
    chk("R12 rxd ignored", 32'(rx_valid), 0);
    rxd = 1'b1;
    @(negedge clk);
    single_wire = 1'b0;
    @(negedge clk);
    chk("R12 oe full duplex", 32'(txd_oe), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule